// File: doc/BRIEF.md
# Signed Divide-by-Constant Unit

This block divides a 32-bit two's-complement dividend by one divisor taken from a small fixed set, without any iterative divider. The divisor is chosen by a 4-bit select code that arrives with each operand. Every result appears one clock after its operand and is rounded toward zero, exactly as signed integer division in C or SystemVerilog.

Two datapaths produce the result. Divisors that are not powers of two go through a reciprocal path:
- a signed 32x32 multiply by a stored magic constant, keeping the upper word of the product;
- for the divisor 7 only, the dividend is added back to that upper word;
- an arithmetic right shift by an amount set for each divisor;
- the sign bit of the shifted value is added back in, so negative quotients round toward zero instead of toward minus infinity.

Divisors 2, 4 and 8 go through a bias-then-shift path. It adds 2^k-1 only when the dividend is negative, then shifts right arithmetically by k. Select codes that name no divisor give a zero quotient and raise an error flag next to the valid strobe.

The block is meant for a pipeline where a divide by a known small constant must finish in a single stage. A long divide that stalls the stream is not acceptable there.

Top module: `const_div_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `out_err` and `quotient` are all cleared to zero at that edge.
- R2: `out_valid` equals the value of `in_valid` at the previous rising edge.
- R3: Select codes map to divisors as follows: 0→2, 1→3, 2→4, 3→5, 4→6, 5→7, 6→8, 7→9, 8→10, 9→100. For codes 1, 3, 4, 5, 7, 8 and 9 the quotient is the signed dividend divided by the divisor, truncated toward zero.
- R4: For codes 0, 2 and 6 (divisors 2, 4, 8) the quotient is the signed dividend divided by the divisor, truncated toward zero.
- R5: The dividends 0x80000000, 0x7FFFFFFF, 0xFFFFFFFF (-1) and 0 give the truncated-toward-zero quotient for every code from 0 to 9.
- R6: For select codes 10 to 15, a valid operand yields `quotient` = 0 and `out_err` = 1 one cycle later.
- R7: For select codes 0 to 9, a valid operand yields `out_err` = 0 one cycle later.
- R8: When `in_valid` is low at a rising edge outside reset, `quotient` and `out_err` keep their values, whatever `dividend` and `sel` hold.
- R9: The sign of the quotient never differs from the sign of the dividend: a non-negative dividend gives a non-negative quotient, and a negative dividend gives a negative or zero quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| dividend | input | 32 | Signed dividend |
| sel | input | 4 | Divisor select code |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| quotient | output | 32 | Signed quotient, truncated toward zero |
| out_err | output | 1 | High with the result when the select code names no divisor |

## Verification
The cases that are hardest to reach from the ports are negative dividends that are exact multiples of the divisor. In those cases the sign-bit correction must cancel an off-by-one exactly. The divide-by-7 add-back at the two extremes of the range is equally hard, because the upper product word and the dividend nearly cancel there. Random operands seldom land on these values. The vector table therefore lists exact negative multiples of each divisor, their neighbours at plus and minus one, and both range limits, and every code is swept over all of them. A long random sweep across all ten divisors follows, and every result is compared against the language's own signed division.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int DATA_W    = 32;
    localparam int SEL_W     = 4;
    localparam int SHIFT_W   = 3;
    localparam int NUM_CODES = 10;

    typedef enum logic [1:0] {
        PATH_NONE  = 2'd0,
        PATH_RECIP = 2'd1,
        PATH_POW2  = 2'd2
    } path_e;

    typedef struct packed {
        path_e              path;
        logic [DATA_W-1:0]  magic;
        logic               add_back;
        logic [SHIFT_W-1:0] shift;
    } div_cfg_t;

    function automatic div_cfg_t make_cfg(path_e p, logic [DATA_W-1:0] m,
                                          logic ab, logic [SHIFT_W-1:0] s);
        div_cfg_t c;
        c.path     = p;
        c.magic    = m;
        c.add_back = ab;
        c.shift    = s;
        return c;
    endfunction

endpackage

// File: rtl/cdiv_decode.sv
module cdiv_decode
    import cdiv_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output div_cfg_t         cfg
);

    always_comb begin
        case (sel)
            4'd0:    cfg = make_cfg(PATH_POW2,  32'h0000_0000, 1'b0, 3'd1);
            4'd1:    cfg = make_cfg(PATH_RECIP, 32'h5555_5556, 1'b0, 3'd0);
            4'd2:    cfg = make_cfg(PATH_POW2,  32'h0000_0000, 1'b0, 3'd2);
            4'd3:    cfg = make_cfg(PATH_RECIP, 32'h6666_6667, 1'b0, 3'd1);
            4'd4:    cfg = make_cfg(PATH_RECIP, 32'h2AAA_AAAB, 1'b0, 3'd0);
            4'd5:    cfg = make_cfg(PATH_RECIP, 32'h9249_2493, 1'b1, 3'd2);
            4'd6:    cfg = make_cfg(PATH_POW2,  32'h0000_0000, 1'b0, 3'd3);
            4'd7:    cfg = make_cfg(PATH_RECIP, 32'h38E3_8E39, 1'b0, 3'd1);
            4'd8:    cfg = make_cfg(PATH_RECIP, 32'h6666_6667, 1'b0, 3'd2);
            4'd9:    cfg = make_cfg(PATH_RECIP, 32'h51EB_851F, 1'b0, 3'd5);
            default: cfg = make_cfg(PATH_NONE,  32'h0000_0000, 1'b0, 3'd0);
        endcase
    end

endmodule

// File: rtl/cdiv_recip_path.sv
module cdiv_recip_path
    import cdiv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]       num,
    input  logic [W-1:0]       magic,
    input  logic               add_back,
    input  logic [SHIFT_W-1:0] shift,
    output logic [W-1:0]       q
);

    localparam int PW = 2 * W;

    logic signed [PW-1:0] num_ext;
    logic signed [PW-1:0] mag_ext;
    logic signed [PW-1:0] prod;
    logic        [W-1:0]  hi_word;
    logic        [W-1:0]  summed;
    logic signed [W-1:0]  shifted;

    assign num_ext = {{W{num[W-1]}}, num};
    assign mag_ext = {{W{magic[W-1]}}, magic};
    assign prod    = num_ext * mag_ext;
    assign hi_word = prod[PW-1:W];

    // Add-back keeps the magic constant inside 32 bits for divisors whose
    // exact reciprocal needs one extra bit.
    assign summed  = add_back ? (hi_word + num) : hi_word;
    assign shifted = $signed(summed) >>> shift;

    // Floor becomes truncation: a negative intermediate gains one.
    assign q = shifted + {{(W-1){1'b0}}, shifted[W-1]};

endmodule

// File: rtl/cdiv_pow2_path.sv
module cdiv_pow2_path
    import cdiv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]       num,
    input  logic [SHIFT_W-1:0] shift,
    output logic [W-1:0]       q
);

    logic [W-1:0] one_hot;
    logic [W-1:0] bias;
    logic [W-1:0] biased;

    assign one_hot = {{(W-1){1'b0}}, 1'b1} << shift;
    assign bias    = num[W-1] ? (one_hot - {{(W-1){1'b0}}, 1'b1}) : '0;
    assign biased  = num + bias;
    assign q       = $signed(biased) >>> shift;

endmodule

// File: rtl/const_div_unit.sv
module const_div_unit
    import cdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] dividend,
    input  logic [SEL_W-1:0]  sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] quotient,
    output logic              out_err
);

    div_cfg_t          cfg;
    logic [DATA_W-1:0] q_recip;
    logic [DATA_W-1:0] q_pow2;
    logic [DATA_W-1:0] q_next;
    logic              err_next;

    cdiv_decode i_decode (
        .sel (sel),
        .cfg (cfg)
    );

    cdiv_recip_path #(.W(DATA_W)) i_recip (
        .num      (dividend),
        .magic    (cfg.magic),
        .add_back (cfg.add_back),
        .shift    (cfg.shift),
        .q        (q_recip)
    );

    cdiv_pow2_path #(.W(DATA_W)) i_pow2 (
        .num   (dividend),
        .shift (cfg.shift),
        .q     (q_pow2)
    );

    always_comb begin
        q_next   = '0;
        err_next = 1'b0;
        unique case (cfg.path)
            PATH_RECIP: q_next = q_recip;
            PATH_POW2:  q_next = q_pow2;
            default:    err_next = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            quotient  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                quotient <= q_next;
                out_err  <= err_next;
            end
        end
    end

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
    import cdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] dividend,
    input logic [SEL_W-1:0]  sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] quotient,
    input logic              out_err
);

    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_CODES - 1);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && quotient == '0));

    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r6_bad_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel > LAST_CODE) |=> (out_err && quotient == '0));

    a_r7_good_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel <= LAST_CODE) |=> !out_err);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(quotient) && $stable(out_err)));

    a_r9_sign_pos: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel <= LAST_CODE && !dividend[DATA_W-1]) |=> !quotient[DATA_W-1]);

    a_r9_sign_neg: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel <= LAST_CODE && dividend[DATA_W-1])
            |=> (quotient[DATA_W-1] || quotient == '0));

endmodule

bind const_div_unit cdiv_checker i_chk (.*);

// File: tb/test_const_div_unit.sv
`timescale 1ns/1ps
module test_const_div_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] dividend = '0;
    logic [3:0]  sel = '0;
    logic        out_valid;
    logic [31:0] quotient;
    logic        out_err;

    int n_run  = 0;
    int n_fail = 0;

    localparam int NVEC = 24;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000,
        32'h0000_0001, 32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFE,
        -32'sd3, -32'sd4, -32'sd5, -32'sd6, -32'sd7, -32'sd8,
        -32'sd9, -32'sd10, -32'sd100, -32'sd101, -32'sd99, -32'sd15,
        32'd100, 32'd99, 32'd63, 32'h1234_5678
    };

    const_div_unit i_const_div_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .dividend  (dividend),
        .sel       (sel),
        .out_valid (out_valid),
        .quotient  (quotient),
        .out_err   (out_err)
    );

    always #4 clk = ~clk;

    function automatic int divisor_of(logic [3:0] code);
        case (code)
            4'd0: return 2;
            4'd1: return 3;
            4'd2: return 4;
            4'd3: return 5;
            4'd4: return 6;
            4'd5: return 7;
            4'd6: return 8;
            4'd7: return 9;
            4'd8: return 10;
            4'd9: return 100;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] code);
        case (code)
            4'd0, 4'd2, 4'd6: return "R4";
            default:          return (code > 4'd9) ? "R6" : "R3";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_one(logic [31:0] n, logic [3:0] code, string tag);
        int d;
        logic [31:0] exp_q;
        d = divisor_of(code);
        exp_q = (d == 0) ? 32'h0 : 32'($signed(n) / d);
        @(negedge clk);
        dividend = n;
        sel      = code;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " quotient"}, quotient, exp_q);
        check({tag, " err (R6/R7)"}, {31'b0, out_err}, {31'b0, d == 0});
        check("R2 out_valid", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 quotient", quotient, 32'h0);
        check("R1 out_err", {31'b0, out_err}, 32'd0);
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;

        // R3 R4 R5 R6 R7: table sweep over every code
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < NVEC; i++) begin
                run_one(VEC[i], 4'(c), (i < 4 && c < 10) ? "R5" : tag_of(4'(c)));
            end
        end

        // R3 R4: random sweep
        for (int i = 0; i < 3000; i++) begin
            run_one($urandom, 4'(i % 10), tag_of(4'(i % 10)));
        end

        // R2 and R8: idle cycle with changing inputs keeps result
        run_one(32'hFFFF_FF9C, 4'd9, "R3");           // -100/100 = -1
        @(negedge clk);
        dividend = 32'h7FFF_FFFF;
        sel      = 4'd12;
        @(negedge clk);
        check("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R8 hold quotient", quotient, 32'hFFFF_FFFF);
        check("R8 hold err", {31'b0, out_err}, 32'd0);

        // R6 then hold of the error flag (R8)
        run_one(32'd77, 4'd15, "R6");
        @(negedge clk);
        sel = 4'd1;
        @(negedge clk);
        check("R8 hold err high", {31'b0, out_err}, 32'd1);

        // R1 reset in the middle of a run
        run_one(32'd700, 4'd5, "R3");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 mid quotient", quotient, 32'h0);
        check("R1 mid out_valid", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule